// File: doc/BRIEF.md
# Shadow-Tag Snoop Filter

This block sits between a system bus and one processor. It holds a shadow of the processor's first-level tag directory: one tag and one MESI state per set, in a direct-mapped layout. Every snooped system-bus transaction is looked up against this shadow. A plain read that hits a Shared line is answered from the shadow alone with a shared response. The processor is not involved, so its address bus stays free and the system bus sees no retry. A plain read that misses gets a clean response at once.

Reads that hit an Exclusive or Modified line, and every snoop that is not a plain read, go to the processor through a forward request. The request holds the filter busy until the processor returns its verdict. That verdict is then passed out as the final snoop response. The processor side keeps the shadow current with tag-update events: allocate, change-state and invalidate. Each is written on the cycle it arrives and takes precedence over a snoop to the same set.

Top module: `snoop_filter`

## Requirements
- R1: After reset, `rsp_valid` and `fwd_valid` are 0, `snp_ready` is 1, and every shadow entry is Invalid, so a read snoop to any address gets a clean response.
- R2: A read snoop (`snp_kind` 0) whose set holds a matching tag in state Shared (state code 1) gives `rsp_valid`=1, `rsp_shared`=1 and `rsp_retry`=0 on the cycle after acceptance, with `fwd_valid` staying 0.
- R3: A read snoop that hits a matching tag in state Exclusive (code 2) or Modified (code 3) raises `fwd_valid` on the cycle after acceptance, with `fwd_addr` equal to the snoop address and `fwd_kind` equal to 0, and gives no response on that cycle.
- R4: A snoop of any kind other than read (1 read-with-intent-to-modify, 2 kill, 3 clean) is forwarded to the processor whatever the shadow state, including a miss. The kind is carried on `fwd_kind`.
- R5: A read snoop whose set is Invalid (code 0), or whose tag differs, gives `rsp_valid`=1 with `rsp_shared`=0 and `rsp_retry`=0 on the cycle after acceptance, and is not forwarded.
- R6: While a forward is outstanding, `fwd_valid`, `fwd_addr` and `fwd_kind` hold steady until `cpu_rsp_valid` is seen. On the next cycle `rsp_valid` is 1, `rsp_shared` and `rsp_retry` equal the processor's values, and `fwd_valid` is 0.
- R7: While a forward is outstanding, `snp_ready` is 0 and a presented snoop is not accepted: it produces no response and leaves the forward unchanged.
- R8: A tag update is written at the clock edge on which `upd_valid` is sampled. A snoop presented in the same cycle to the same set sees `snp_ready`=0 and is held; on the next cycle it is looked up against the updated entry.
- R9: Update kinds: 1 allocate writes the tag and the given state. 2 change-state writes the given state only if the stored tag matches. 3 invalidate sets Invalid only if the stored tag matches. A non-matching change-state or invalidate leaves the entry as it was.
- R10: An update to a different set in the same cycle does not hold a snoop back: `snp_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snp_valid | input | 1 | Snoop transaction presented |
| snp_addr | input | ADDR_W | Snoop address |
| snp_kind | input | 2 | Snoop kind: 0 read, 1 read-with-intent-to-modify, 2 kill, 3 clean |
| snp_ready | output | 1 | Snoop accepted this cycle when high with snp_valid |
| upd_valid | input | 1 | Tag update presented |
| upd_kind | input | 2 | Update kind: 0 none, 1 allocate, 2 change state, 3 invalidate |
| upd_addr | input | ADDR_W | Line address of the update |
| upd_state | input | 2 | MESI state for allocate or change state |
| fwd_valid | output | 1 | Forward request to the processor outstanding |
| fwd_addr | output | ADDR_W | Forwarded snoop address |
| fwd_kind | output | 2 | Forwarded snoop kind |
| cpu_rsp_valid | input | 1 | Processor has finished the forwarded snoop |
| cpu_rsp_shared | input | 1 | Processor shared verdict |
| cpu_rsp_retry | input | 1 | Processor retry verdict |
| rsp_valid | output | 1 | Final snoop response valid (one cycle) |
| rsp_shared | output | 1 | Shared response |
| rsp_retry | output | 1 | Retry response |

## Verification
The assertions take three things for granted about the processor side. `cpu_rsp_valid` only arrives while a forward is outstanding. Update states are legal MESI codes. An allocate never asks for state Invalid where a hit is expected. The bench keeps within this: it raises `cpu_rsp_valid` only after it has seen `fwd_valid`, and each update is a single-cycle pulse with a chosen tag and state. Snoop inputs are held stable while `snp_ready` is low, so an accepted snoop is the one the bench intended. Same-set and different-set collisions with updates are set up on purpose to exercise the stall rule.

// File: rtl/snf_pkg.sv
// Shared encodings for the shadow-tag snoop filter.
// Assumes 2-bit codes everywhere; values are visible at the ports.
package snf_pkg;
    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_e;

    typedef enum logic [1:0] {
        SK_READ  = 2'd0,
        SK_RWITM = 2'd1,
        SK_KILL  = 2'd2,
        SK_CLEAN = 2'd3
    } snp_kind_e;

    typedef enum logic [1:0] {
        UK_NOP   = 2'd0,
        UK_ALLOC = 2'd1,
        UK_SETST = 2'd2,
        UK_INVAL = 2'd3
    } upd_kind_e;

    typedef enum logic [1:0] {
        DEC_CLEAN  = 2'd0,
        DEC_SHARED = 2'd1,
        DEC_FWD    = 2'd2
    } dec_e;
endpackage

// File: rtl/snf_dir.sv
// Direct-mapped shadow directory: one tag and MESI state per set.
// One write port for processor-side updates, one combinational read port.
// Assumes the caller keeps a snoop off a set that is written this cycle.
module snf_dir
    import snf_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int IDX_W = 4,
    parameter int TAG_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_kind,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [1:0]       wr_state,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic [1:0]       rd_state
);
    logic [TAG_W-1:0] tag_q [SETS];
    logic [1:0]       st_q  [SETS];
    logic [SETS-1:0]  sel;

    // Per-set write select decoded from the update index.
    for (genvar g = 0; g < SETS; g++) begin : g_sel
        assign sel[g] = wr_en && (wr_idx == IDX_W'(g));
    end

    // Apply allocate / change-state / invalidate to the selected set.
    always_ff @(posedge clk) begin
        for (int i = 0; i < SETS; i++) begin
            if (!rst_n) begin
                tag_q[i] <= '0;
                st_q[i]  <= ST_I;
            end else if (sel[i]) begin
                case (upd_kind_e'(wr_kind))
                    UK_ALLOC: begin
                        tag_q[i] <= wr_tag;
                        st_q[i]  <= wr_state;
                    end
                    UK_SETST: if (tag_q[i] == wr_tag) st_q[i] <= wr_state;
                    UK_INVAL: if (tag_q[i] == wr_tag) st_q[i] <= ST_I;
                    default: ;
                endcase
            end
        end
    end

    // Read port used by the snoop lookup.
    always_comb begin
        rd_tag   = tag_q[rd_idx];
        rd_state = st_q[rd_idx];
    end

    // R9: an allocate lands in the addressed set on the next cycle.
    a_r9_alloc_written: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == UK_ALLOC) |=>
            (tag_q[$past(wr_idx)] == $past(wr_tag) && st_q[$past(wr_idx)] == $past(wr_state)));

    // R9: an invalidate with a foreign tag leaves the state alone.
    a_r9_inval_mismatch_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == UK_INVAL && tag_q[wr_idx] != wr_tag) |=>
            (st_q[$past(wr_idx)] == $past(st_q[wr_idx])));
endmodule

// File: rtl/snf_lookup.sv
// Classifies one snoop against the shadow entry of its set.
// Plain reads: Shared hit answered locally, miss answered clean,
// Exclusive/Modified hit forwarded. Every other kind is forwarded.
module snf_lookup
    import snf_pkg::*;
#(
    parameter int TAG_W = 23
) (
    input  logic [TAG_W-1:0] ent_tag,
    input  logic [1:0]       ent_state,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic [1:0]       snp_kind,
    output logic             hit,
    output logic [1:0]       dec
);
    // Hit test and decision table.
    always_comb begin
        hit = (ent_state != ST_I) && (ent_tag == snp_tag);
        if (snp_kind != SK_READ)   dec = DEC_FWD;
        else if (!hit)             dec = DEC_CLEAN;
        else if (ent_state == ST_S) dec = DEC_SHARED;
        else                       dec = DEC_FWD;
    end
endmodule

// File: rtl/snf_ctrl.sv
// Response and forward sequencer. Local decisions give a one-cycle
// response; a forward holds busy until the processor answers, whose
// verdict is then passed out. Assumes cpu_rsp_valid only while busy.
module snf_ctrl
    import snf_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic [1:0]        dec,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [1:0]        snp_kind,
    input  logic              cpu_rsp_valid,
    input  logic              cpu_rsp_shared,
    input  logic              cpu_rsp_retry,
    output logic              busy,
    output logic              fwd_valid,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [1:0]        fwd_kind,
    output logic              rsp_valid,
    output logic              rsp_shared,
    output logic              rsp_retry
);
    // Sequence local answers, forwards and returned verdicts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            fwd_addr   <= '0;
            fwd_kind   <= SK_READ;
            rsp_valid  <= 1'b0;
            rsp_shared <= 1'b0;
            rsp_retry  <= 1'b0;
        end else begin
            rsp_valid  <= 1'b0;
            rsp_shared <= 1'b0;
            rsp_retry  <= 1'b0;
            if (busy) begin
                if (cpu_rsp_valid) begin
                    busy       <= 1'b0;
                    rsp_valid  <= 1'b1;
                    rsp_shared <= cpu_rsp_shared;
                    rsp_retry  <= cpu_rsp_retry;
                end
            end else if (acc) begin
                case (dec_e'(dec))
                    DEC_SHARED: begin
                        rsp_valid  <= 1'b1;
                        rsp_shared <= 1'b1;
                    end
                    DEC_CLEAN: rsp_valid <= 1'b1;
                    default: begin
                        busy     <= 1'b1;
                        fwd_addr <= snp_addr;
                        fwd_kind <= snp_kind;
                    end
                endcase
            end
        end
    end

    assign fwd_valid = busy;

    // R2: Shared read hit answered locally, never retried, never forwarded.
    a_r2_shared_local: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && dec == DEC_SHARED) |=> (rsp_valid && rsp_shared && !rsp_retry && !fwd_valid));

    // R5: read miss answered clean without forward.
    a_r5_clean_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && dec == DEC_CLEAN) |=> (rsp_valid && !rsp_shared && !rsp_retry && !fwd_valid));

    // R6: forward request holds until the processor answers.
    a_r6_fwd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && !cpu_rsp_valid) |=> (fwd_valid && $stable(fwd_addr) && $stable(fwd_kind)));

    // R6: processor verdict passed out on the following cycle.
    a_r6_verdict_passed: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && cpu_rsp_valid) |=>
            (rsp_valid && !fwd_valid && rsp_shared == $past(cpu_rsp_shared)
             && rsp_retry == $past(cpu_rsp_retry)));

    // R6: a response and a live forward never coexist.
    a_r6_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_valid, fwd_valid}));
endmodule

// File: rtl/snoop_filter.sv
// Shadow-tag snoop filter top. Splits addresses into tag/set/offset,
// applies processor-side updates to the shadow directory, classifies
// snoops and runs the forward handshake. Updates win over a snoop to
// the same set in the same cycle; the snoop waits one cycle.
module snoop_filter
    import snf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5,
    parameter int SETS   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [1:0]        snp_kind,
    output logic              snp_ready,
    input  logic              upd_valid,
    input  logic [1:0]        upd_kind,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [1:0]        upd_state,
    output logic              fwd_valid,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [1:0]        fwd_kind,
    input  logic              cpu_rsp_valid,
    input  logic              cpu_rsp_shared,
    input  logic              cpu_rsp_retry,
    output logic              rsp_valid,
    output logic              rsp_shared,
    output logic              rsp_retry
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

    logic [IDX_W-1:0] snp_idx, upd_idx;
    logic [TAG_W-1:0] snp_tag, upd_tag, ent_tag;
    logic [1:0]       ent_state, dec;
    logic             hit, busy, set_clash, acc;

    // Address field split for both ports.
    always_comb begin
        snp_idx = snp_addr[OFF_W +: IDX_W];
        snp_tag = snp_addr[ADDR_W-1 -: TAG_W];
        upd_idx = upd_addr[OFF_W +: IDX_W];
        upd_tag = upd_addr[ADDR_W-1 -: TAG_W];
    end

    // Acceptance: idle and no update to the same set this cycle.
    always_comb begin
        set_clash = upd_valid && (upd_kind != UK_NOP) && (upd_idx == snp_idx);
        snp_ready = !busy && !set_clash;
        acc       = snp_valid && snp_ready;
    end

    snf_dir #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_dir (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (upd_valid),
        .wr_kind (upd_kind),
        .wr_idx  (upd_idx),
        .wr_tag  (upd_tag),
        .wr_state(upd_state),
        .rd_idx  (snp_idx),
        .rd_tag  (ent_tag),
        .rd_state(ent_state)
    );

    snf_lookup #(.TAG_W(TAG_W)) u_lookup (
        .ent_tag  (ent_tag),
        .ent_state(ent_state),
        .snp_tag  (snp_tag),
        .snp_kind (snp_kind),
        .hit      (hit),
        .dec      (dec)
    );

    snf_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc           (acc),
        .dec           (dec),
        .snp_addr      (snp_addr),
        .snp_kind      (snp_kind),
        .cpu_rsp_valid (cpu_rsp_valid),
        .cpu_rsp_shared(cpu_rsp_shared),
        .cpu_rsp_retry (cpu_rsp_retry),
        .busy          (busy),
        .fwd_valid     (fwd_valid),
        .fwd_addr      (fwd_addr),
        .fwd_kind      (fwd_kind),
        .rsp_valid     (rsp_valid),
        .rsp_shared    (rsp_shared),
        .rsp_retry     (rsp_retry)
    );

    // R7: no snoop is accepted while a forward is outstanding.
    a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> !snp_ready);

    // R8: same-set update stalls a concurrent snoop.
    a_r8_update_first: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && upd_valid && upd_kind != UK_NOP && upd_idx == snp_idx) |-> !snp_ready);

    // R3: an accepted read hitting Exclusive or Modified is forwarded.
    a_r3_excl_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && snp_kind == SK_READ && hit && (ent_state == ST_E || ent_state == ST_M))
            |=> (fwd_valid && !rsp_valid));

    // R4: an accepted non-read snoop is always forwarded.
    a_r4_nonread_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && snp_kind != SK_READ) |=> (fwd_valid && fwd_kind == $past(snp_kind)));
endmodule

// File: tb/snoop_filter_bench.sv
`timescale 1ns/1ps
module snoop_filter_bench;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              snp_valid = 1'b0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic [1:0]        snp_kind = 2'd0;
    logic              snp_ready;
    logic              upd_valid = 1'b0;
    logic [1:0]        upd_kind = 2'd0;
    logic [ADDR_W-1:0] upd_addr = '0;
    logic [1:0]        upd_state = 2'd0;
    logic              fwd_valid;
    logic [ADDR_W-1:0] fwd_addr;
    logic [1:0]        fwd_kind;
    logic              cpu_rsp_valid = 1'b0;
    logic              cpu_rsp_shared = 1'b0;
    logic              cpu_rsp_retry = 1'b0;
    logic              rsp_valid, rsp_shared, rsp_retry;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    snoop_filter u_snoop_filter (.*);

    function automatic logic [ADDR_W-1:0] la(input int set, input int tag);
        return ADDR_W'((tag << 9) | (set << 5));
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic upd(input int kind, input int set, input int tag, input int st);
        @(negedge clk);
        upd_valid = 1'b1; upd_kind = 2'(kind); upd_addr = la(set, tag); upd_state = 2'(st);
        @(negedge clk);
        upd_valid = 1'b0; upd_kind = 2'd0;
    endtask

    // Present a snoop for one cycle; on return outputs of the edge are visible.
    task automatic snoop(input int kind, input int set, input int tag);
        @(negedge clk);
        snp_valid = 1'b1; snp_kind = 2'(kind); snp_addr = la(set, tag);
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic expect_local(input string req, input bit sh);
        chk({req, " rsp_valid"}, rsp_valid, 1);
        chk({req, " rsp_shared"}, rsp_shared, sh);
        chk({req, " rsp_retry"}, rsp_retry, 0);
        chk({req, " fwd_valid"}, fwd_valid, 0);
    endtask

    task automatic answer(input string req, input bit sh, input bit rt);
        @(negedge clk);
        cpu_rsp_valid = 1'b1; cpu_rsp_shared = sh; cpu_rsp_retry = rt;
        @(negedge clk);
        cpu_rsp_valid = 1'b0;
        chk({req, " verdict valid"}, rsp_valid, 1);
        chk({req, " verdict shared"}, rsp_shared, sh);
        chk({req, " verdict retry"}, rsp_retry, rt);
        chk({req, " fwd dropped"}, fwd_valid, 0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 fwd_valid", fwd_valid, 0);
        chk("R1 snp_ready", snp_ready, 1);
        snoop(0, 0, 0);
        expect_local("R1 empty dir", 0);
        snoop(0, 7, 3);
        expect_local("R1 empty dir 2", 0);
    endtask

    task automatic t_shared_read;
        upd(1, 1, 'h12, 1);
        snoop(0, 1, 'h12);
        expect_local("R2 shared hit", 1);
        @(negedge clk);
        chk("R2 one-cycle pulse", rsp_valid, 0);
    endtask

    task automatic t_exclusive_read;
        upd(1, 2, 'h34, 2);
        snoop(0, 2, 'h34);
        chk("R3 fwd_valid E", fwd_valid, 1);
        chk("R3 fwd_addr", fwd_addr, la(2, 'h34));
        chk("R3 fwd_kind", fwd_kind, 0);
        chk("R3 no rsp", rsp_valid, 0);
        // R7: a snoop offered while busy is refused
        snp_valid = 1'b1; snp_kind = 2'd0; snp_addr = la(1, 'h12);
        #1 chk("R7 snp_ready low", snp_ready, 0);
        @(negedge clk);
        snp_valid = 1'b0;
        chk("R7 no rsp while busy", rsp_valid, 0);
        chk("R6 fwd_addr held", fwd_addr, la(2, 'h34));
        chk("R6 fwd_valid held", fwd_valid, 1);
        answer("R6 E", 0, 1);
        upd(1, 5, 'h55, 3);
        snoop(0, 5, 'h55);
        chk("R3 fwd_valid M", fwd_valid, 1);
        answer("R6 M", 1, 0);
    endtask

    task automatic t_nonread;
        snoop(1, 1, 'h12);
        chk("R4 rwitm on S fwd", fwd_valid, 1);
        chk("R4 rwitm kind", fwd_kind, 1);
        chk("R4 no local rsp", rsp_valid, 0);
        answer("R4 rwitm", 0, 0);
        snoop(2, 9, 'h77);
        chk("R4 kill on miss fwd", fwd_valid, 1);
        chk("R4 kill kind", fwd_kind, 2);
        answer("R4 kill", 0, 0);
        snoop(3, 0, 0);
        chk("R4 clean kind", fwd_kind, 3);
        answer("R4 clean", 0, 1);
    endtask

    task automatic t_read_miss;
        snoop(0, 1, 'h13);
        expect_local("R5 tag mismatch", 0);
        snoop(0, 6, 'h12);
        expect_local("R5 invalid set", 0);
    endtask

    task automatic t_same_set_update;
        @(negedge clk);
        upd_valid = 1'b1; upd_kind = 2'd1; upd_addr = la(3, 5); upd_state = 2'd1;
        snp_valid = 1'b1; snp_kind = 2'd0; snp_addr = la(3, 5);
        #1 chk("R8 stalled", snp_ready, 0);
        @(negedge clk);
        upd_valid = 1'b0; upd_kind = 2'd0;
        chk("R8 no rsp while held", rsp_valid, 0);
        #1 chk("R8 ready next", snp_ready, 1);
        @(negedge clk);
        snp_valid = 1'b0;
        expect_local("R8 sees new entry", 1);
    endtask

    task automatic t_other_set_update;
        @(negedge clk);
        upd_valid = 1'b1; upd_kind = 2'd1; upd_addr = la(4, 9); upd_state = 2'd2;
        snp_valid = 1'b1; snp_kind = 2'd0; snp_addr = la(3, 5);
        #1 chk("R10 not stalled", snp_ready, 1);
        @(negedge clk);
        upd_valid = 1'b0; upd_kind = 2'd0; snp_valid = 1'b0;
        expect_local("R10 answered", 1);
    endtask

    task automatic t_update_rules;
        upd(2, 3, 6, 2);
        snoop(0, 3, 5);
        expect_local("R9 setst mismatch ignored", 1);
        upd(3, 3, 6, 0);
        snoop(0, 3, 5);
        expect_local("R9 inval mismatch ignored", 1);
        upd(2, 3, 5, 2);
        snoop(0, 3, 5);
        chk("R9 setst match to E fwd", fwd_valid, 1);
        answer("R9 setst", 0, 0);
        upd(3, 3, 5, 0);
        snoop(0, 3, 5);
        expect_local("R9 inval match", 0);
        upd(1, 3, 8, 1);
        snoop(0, 3, 8);
        expect_local("R9 realloc new tag", 1);
        snoop(0, 3, 5);
        expect_local("R9 old tag gone", 0);
    endtask

    initial begin
        t_reset();
        t_shared_read();
        t_exclusive_read();
        t_nonread();
        t_read_miss();
        t_same_set_update();
        t_other_set_update();
        t_update_rules();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule